// File: doc/BRIEF.md
# Clocked Shift-Register Serial Port

This block is the fixed-rate synchronous mode of a small controller's serial port. It serialises one byte at a time onto a shared data line and drives a shift clock alongside it, so an external shift register can be clocked directly. Receive works the other way round: the port generates the same shift clock, leaves the data line undriven, and gathers eight bits from it. The bit rate is tied to the system clock, with one bit every `BIT_CLKS` cycles (12 by default).

Software sees two byte-wide registers. A write to the buffer register starts a transmit when the port is idle. The control register holds a receive-enable bit and two completion flags. A receive starts whenever the port is idle, receive-enable is set and the receive flag is clear. Each flag is set by hardware when its transfer ends and stays set until software writes it back to zero. Bits travel least significant first. The shift clock rests high and goes low for the first half of each bit's clock period. Output data changes a fixed two cycles after each rising edge, which leaves ten cycles of setup before the next one. The input is captured at the rising edge.

Top module: `sync_serial_port`

## Requirements
- R1: While reset is held and right after it is released, the control register reads 00h, the shift clock is high and the data line is not driven (`serOe` = 0).
- R2: A buffer write while the port is idle starts a transmit of that byte, least significant bit first. The buffer read port then shows the byte.
- R3: During a transfer the shift clock has a period of 12 cycles. It is low for 6 cycles, then high for 6, and the rising edge falls 10 cycles into each bit slot.
- R4: Transmit data is stable for at least 10 cycles before each rising shift clock edge. It does not change until 2 cycles after that edge.
- R5: `serOe` is high from the cycle after the buffer write until the transfer ends. The transmit-done flag (control bit 1) is first seen 96 cycles after the write edge, and not at 95.
- R6: The completion flags stay set until a control write clears them. A control write loads bit 4 (receive enable), bit 1 (transmit done) and bit 0 (receive done).
- R7: A receive starts one cycle after receive-enable is seen with the receive-done flag clear. `serOe` stays low throughout. Eight bits are captured LSB first, the byte appears on the buffer read port, and receive-done is first seen 97 cycles after the control write edge.
- R8: The serial input needs no hold time after a rising shift clock edge. It may change in the half cycle just after that edge without corrupting the captured bit.
- R9: No receive starts while receive-done is set or receive-enable is clear. Clearing receive-done while enable stays set starts a new receive.
- R10: A buffer write during a transfer is ignored. Both the byte on the line and the buffer read port are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufWr | input | 1 | Buffer write strobe |
| bufWrData | input | 8 | Byte to transmit |
| ctlWr | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control write value (bit 4 enable, bit 1 tx done, bit 0 rx done) |
| bufRdData | output | 8 | Buffer register contents |
| ctlRdData | output | 8 | Control register contents, unused bits read 0 |
| shiftClk | output | 1 | Shift clock, idles high |
| serOut | output | 1 | Serial data out |
| serOe | output | 1 | Drive enable for the serial data line |
| serIn | input | 1 | Serial data in |

## Verification
A transmit launched at write edge E raises the drive enable in the cycle after E. Its first rising shift clock edge is at E+10, with later edges every 12 cycles, and its done flag appears after E+96. A receive is one cycle later on each of these counts, so its flag appears after E+97. The bench samples at falling clock edges and counts edges from the write strobe, checking each flag both in the cycle before it is due and in the cycle it is due. A line monitor measures the setup, hold, low time and period of every shift clock edge in cycles and compares each assembled byte with a queue filled by the driver. For receive, the stimulus changes the input in the half cycle just after each rising edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // capture write byte into shifter and buffer
    logic isTx;      // current transfer direction
    logic shiftOut;  // advance transmit shifter at a bit boundary
    logic sampleIn;  // capture serial input at rising shift clock
    logic finish;    // last bit slot ends this cycle
  } sioStrobe_t;

  localparam int RXDONE_BIT = 0;
  localparam int TXDONE_BIT = 1;
  localparam int RXEN_BIT   = 4;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int BIT_CLKS  = 12,
  parameter int HOLD_CLKS = 2,
  parameter int DATA_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bufWr,
  input  logic             ctlWr,
  input  logic [7:0]       ctlWrData,
  output sioStrobe_t       strb,
  output logic             shiftClk,
  output logic             serOe,
  output logic [7:0]       ctlRdData
);
  localparam int PH_W      = $clog2(BIT_CLKS);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int RISE_PH   = BIT_CLKS - HOLD_CLKS;
  localparam int FALL_PH   = RISE_PH - BIT_CLKS / 2;
  localparam int SAMPLE_PH = RISE_PH - 1;
  localparam int LAST_PH   = BIT_CLKS - 1;

  logic             busy, txMode;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitIdx;
  logic             rxEn, txDone, rxDone;
  logic             startTx, startRx, lastPh, lastBit;
  logic             unusedCtlBits;

  assign unusedCtlBits = ^{ctlWrData[7:5], ctlWrData[3:2]};

  assign startTx = !busy && bufWr;
  assign startRx = !busy && !bufWr && rxEn && !rxDone;
  assign lastPh  = (phase == PH_W'(LAST_PH));
  assign lastBit = (bitIdx == BIT_W'(DATA_W - 1));

  always_comb begin
    strb          = '0;
    strb.load     = startTx;
    strb.isTx     = txMode;
    strb.shiftOut = busy && txMode && lastPh && !lastBit;
    strb.sampleIn = busy && !txMode && (phase == PH_W'(SAMPLE_PH));
    strb.finish   = busy && lastPh && lastBit;
  end

  assign shiftClk = !(busy && (phase >= PH_W'(FALL_PH)) && (phase < PH_W'(RISE_PH)));
  assign serOe    = busy && txMode;

  always_comb begin
    ctlRdData             = '0;
    ctlRdData[RXEN_BIT]   = rxEn;
    ctlRdData[TXDONE_BIT] = txDone;
    ctlRdData[RXDONE_BIT] = rxDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      txMode <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
      rxEn   <= 1'b0;
      txDone <= 1'b0;
      rxDone <= 1'b0;
    end else begin
      if (startTx || startRx) begin
        busy   <= 1'b1;
        txMode <= startTx;
        phase  <= '0;
        bitIdx <= '0;
      end else if (busy) begin
        if (lastPh) begin
          phase <= '0;
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (ctlWr) begin
        rxEn   <= ctlWrData[RXEN_BIT];
        txDone <= ctlWrData[TXDONE_BIT];
        rxDone <= ctlWrData[RXDONE_BIT];
      end
      if (strb.finish) begin
        if (txMode) txDone <= 1'b1;
        else        rxDone <= 1'b1;
      end
    end
  end

  // R6
  txdone_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone && !ctlWr |=> txDone);
  // R6
  rxdone_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !ctlWr |=> rxDone);
  // R3
  clk_rise_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> busy && (phase == PH_W'(RISE_PH)));
  // R5
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !busy && (txDone || rxDone));
  // R9
  no_rx_while_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && rxDone && !ctlWr && !bufWr |=> !busy);
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.finish && bufWr |=> busy && $stable(txMode));
endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStrobe_t        strb,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] bufRdData
);
  logic [DATA_W-1:0] shifter;
  logic [DATA_W-1:0] bufReg;

  // buffer and shifter carry no reset: contents are undefined at power-up
  always_ff @(posedge clk) begin
    if (strb.load) begin
      shifter <= bufWrData;
      bufReg  <= bufWrData;
    end else begin
      if (strb.sampleIn) shifter <= {serIn, shifter[DATA_W-1:1]};
      if (strb.shiftOut) shifter <= {1'b0, shifter[DATA_W-1:1]};
      if (strb.finish && !strb.isTx) bufReg <= shifter;
    end
  end

  assign serOut    = shifter[0];
  assign bufRdData = bufReg;

  // R4
  tx_bit_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.isTx && !strb.load && !strb.shiftOut && !strb.sampleIn |=> $stable(serOut));
  // R10
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !(strb.finish && !strb.isTx) |=> $stable(bufRdData));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sio_pkg::*;
#(
  parameter int BIT_CLKS  = 12,
  parameter int HOLD_CLKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bufWr,
  input  logic [7:0] bufWrData,
  input  logic       ctlWr,
  input  logic [7:0] ctlWrData,
  output logic [7:0] bufRdData,
  output logic [7:0] ctlRdData,
  output logic       shiftClk,
  output logic       serOut,
  output logic       serOe,
  input  logic       serIn
);
  localparam int DATA_W = 8;

  sioStrobe_t strb;

  sio_ctrl #(.BIT_CLKS(BIT_CLKS), .HOLD_CLKS(HOLD_CLKS), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bufWr(bufWr), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
    .strb(strb), .shiftClk(shiftClk), .serOe(serOe), .ctlRdData(ctlRdData)
  );

  sio_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .bufWrData(bufWrData), .serIn(serIn),
    .serOut(serOut), .bufRdData(bufRdData)
  );
endmodule

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       bufWr = 1'b0, ctlWr = 1'b0, serIn = 1'b0;
  logic [7:0] bufWrData = '0, ctlWrData = '0;
  logic [7:0] bufRdData, ctlRdData;
  logic       shiftClk, serOut, serOe;

  sync_serial_port dut (
    .clk(clk), .rstN(rstN), .bufWr(bufWr), .bufWrData(bufWrData),
    .ctlWr(ctlWr), .ctlWrData(ctlWrData), .bufRdData(bufRdData),
    .ctlRdData(ctlRdData), .shiftClk(shiftClk), .serOut(serOut),
    .serOe(serOe), .serIn(serIn)
  );

  int checks = 0, errors = 0;
  logic [7:0] expQ[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // line monitor state
  int   cyc = 0, sinceChange = 0, sinceRise = 100, lastRise = 0, lastFall = 0;
  int   highRun = 100, riseCount = 0, txBitCnt = 0, rxIdx = 0;
  bit   firstBit = 1, prevClk = 1, prevOe = 0, prevData = 0, rxActive = 0;
  logic [7:0] txAcc = '0, rxBits = '0;

  // monitor: pops expected bytes and checks line timing
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        sinceRise++;
        if (serOe) begin
          if (!prevOe) sinceChange = 0;
          else if (serOut !== prevData) begin
            chk("R4", "hold after rise", (sinceRise >= 2) ? 2 : sinceRise, 2);
            sinceChange = 0;
          end else sinceChange++;
        end
        if (!shiftClk && prevClk) begin
          if (highRun > 6) begin firstBit = 1; txBitCnt = 0; end
          lastFall = cyc;
          highRun = 0;
        end
        if (shiftClk) highRun++;
        if (shiftClk && !prevClk) begin
          riseCount++;
          chk("R3", "low width", cyc - lastFall, 6);
          if (!firstBit) chk("R3", "rise period", cyc - lastRise, 12);
          firstBit = 0;
          lastRise = cyc;
          sinceRise = 0;
          if (serOe) begin
            chk("R4", "setup before rise", (sinceChange >= 10) ? 10 : sinceChange, 10);
            txAcc[txBitCnt[2:0]] = serOut;
            txBitCnt++;
            if (txBitCnt == 8) begin
              if (expQ.size() == 0) chk("R2", "unexpected byte", int'(txAcc), -1);
              else chk("R2", "tx byte", int'(txAcc), int'(expQ.pop_front()));
            end
          end
          // R8: new input bit right after the sampling edge
          if (rxActive) begin
            rxIdx++;
            if (rxIdx < 8) serIn = rxBits[rxIdx[2:0]];
            else rxActive = 0;
          end
        end
      end
      prevClk = shiftClk;
      prevOe = serOe;
      prevData = serOut;
    end
  end

  task automatic ctlWrite(logic [7:0] d);
    @(negedge clk); ctlWr = 1'b1; ctlWrData = d;
    @(posedge clk);
    @(negedge clk); ctlWr = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b);
    expQ.push_back(b);
    @(negedge clk); bufWr = 1'b1; bufWrData = b;
    @(posedge clk);
    @(negedge clk); bufWr = 1'b0;
    chk("R5", "drive enable after write", int'(serOe), 1);
    repeat (95) @(negedge clk);
    chk("R5", "tx done not before 96", int'(ctlRdData[1]), 0);
    @(negedge clk);
    chk("R5", "tx done at 96", int'(ctlRdData[1]), 1);
    chk("R2", "buffer readback", int'(bufRdData), int'(b));
  endtask

  task automatic recvByte(logic [7:0] b);
    rxBits = b; rxIdx = 0; serIn = b[0]; rxActive = 1;
    @(negedge clk); ctlWr = 1'b1; ctlWrData = 8'h10;
    @(posedge clk);
    @(negedge clk); ctlWr = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7", "no drive during receive", int'(serOe), 0);
    repeat (56) @(negedge clk);
    chk("R7", "rx done not before 97", int'(ctlRdData[0]), 0);
    @(negedge clk);
    chk("R7", "rx done at 97", int'(ctlRdData[0]), 1);
    chk("R7", "received byte", int'(bufRdData), int'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "ctl in reset", int'(ctlRdData), 0);
    chk("R1", "shift clock idle", int'(shiftClk), 1);
    chk("R1", "no drive", int'(serOe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ctl after reset", int'(ctlRdData), 0);
    chk("R1", "shift clock after reset", int'(shiftClk), 1);

    sendByte(8'hA5);
    repeat (30) @(negedge clk);
    chk("R6", "tx done sticky", int'(ctlRdData[1]), 1);
    ctlWrite(8'h00);
    chk("R6", "flags cleared", int'(ctlRdData), 0);

    foreach (expQ[i]) ; // queue should be drained by now
    sendByte(8'h01); ctlWrite(8'h00);
    sendByte(8'h80); ctlWrite(8'h00);
    sendByte(8'hFF); ctlWrite(8'h00);
    sendByte(8'h00); ctlWrite(8'h00);

    // R10: write while busy is ignored
    expQ.push_back(8'h3C);
    @(negedge clk); bufWr = 1'b1; bufWrData = 8'h3C;
    @(posedge clk);
    @(negedge clk); bufWr = 1'b0;
    repeat (30) @(negedge clk);
    bufWr = 1'b1; bufWrData = 8'hC3;
    @(negedge clk); bufWr = 1'b0;
    chk("R10", "buffer after busy write", int'(bufRdData), 8'h3C);
    while (!ctlRdData[1]) @(negedge clk);
    chk("R10", "buffer after transfer", int'(bufRdData), 8'h3C);
    ctlWrite(8'h00);

    recvByte(8'h96);
    chk("R6", "rx enable kept", int'(ctlRdData[4]), 1);
    base = riseCount;
    repeat (40) @(negedge clk);
    chk("R9", "no receive while done set", riseCount - base, 0);
    chk("R6", "rx done sticky", int'(ctlRdData[0]), 1);

    recvByte(8'h5A);
    ctlWrite(8'h00);
    base = riseCount;
    repeat (150) @(negedge clk);
    chk("R9", "no receive when disabled", riseCount - base, 0);
    chk("R2", "leftover expected bytes", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule